// File: doc/BRIEF.md
# Row-Hit-First Bank Request Scheduler

This block holds pending memory requests for a memory controller, with one queue for each bank. Each request records a bank index, a row address, the ID of the thread that issued it and a tag. Within a bank's queue, requests stay in arrival order. The controller names a bank. In the same cycle the block offers the oldest request of that bank whose row matches the row currently open in that bank. If no request in that bank hits the open row, it offers the oldest request of that bank instead.

After the controller issues a request, it removes that request by tag. The request may sit anywhere in its bank's queue, and the queue closes the gap while keeping the age order of the remaining requests. A second operation returns the head of a bank's queue and removes it. This lets an outer policy drain requests in pure arrival order.

The open row of each bank comes from one of two places, chosen by a mode input:

- an external bank-state vector supplied by the controller, or
- a private table that records the row of every request removed while the private mode is active.

The private table starts with every bank marked as having no open row. A single flag reports when every queue is empty.

Top module: `rowhit_bank_sched`

## Requirements
- R1: A request accepted on the enqueue port is appended behind all older entries of its own bank. Each bank holds at most DEPTH (8) entries. While the addressed bank is full, `enq_ready` is 0 and a request offered then is dropped.
- R2: While `qry_bank` names a non-empty bank, the `sel_*` outputs show, in the same cycle, the oldest entry of that bank whose row equals the bank's open row, with `sel_hit` = 1. This holds even when older entries of that bank do not hit.
- R3: When no entry of the named bank hits, the `sel_*` outputs show the oldest entry of that bank, with `sel_hit` = 0.
- R4: With `mode_ext` = 1, bank b's open row is `ext_open_row[b*8 +: 8]`, and that value is always treated as valid.
- R5: With `mode_ext` = 0, each bank uses its private open row. Private open rows reset to "none", so no entry hits until the first removal on that bank. A removal in this mode sets the bank's private row to the removed entry's row. A removal made with `mode_ext` = 1 leaves the private row unchanged.
- R6: `rem_valid` deletes, at the next clock edge, the oldest entry of `rem_bank` carrying `rem_tag`, wherever it sits, and keeps the remaining entries in order. The tag must be present in that bank.
- R7: `pop_row`/`pop_thread`/`pop_tag` show the head entry of `pop_bank` in the same cycle. `pop_valid` removes that head at the next edge. A pop never changes any open row. A pop and a removal must not name the same bank in one cycle.
- R8: `empty` is 1 exactly when every bank queue holds no entries, including right after reset.
- R9: `sel_valid` is 0 while the named bank is empty. Raising `qry_valid` on an empty bank is illegal and is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ext | input | 1 | 1: open rows taken from `ext_open_row`; 0: private table |
| ext_open_row | input | NUM_BANKS*8 | External open row per bank, bank b at bits b*8 +: 8 |
| enq_valid | input | 1 | Offer a new request |
| enq_bank | input | BANK_W | Bank of the new request |
| enq_row | input | 8 | Row of the new request |
| enq_thread | input | 2 | Thread ID of the new request |
| enq_tag | input | 4 | Tag of the new request |
| enq_ready | output | 1 | The bank named by `enq_bank` has room |
| qry_valid | input | 1 | Controller consumes the selection for `qry_bank` |
| qry_bank | input | BANK_W | Bank being queried |
| sel_valid | output | 1 | Queried bank holds at least one entry |
| sel_hit | output | 1 | Selected entry hits the open row |
| sel_row | output | 8 | Row of the selected entry |
| sel_thread | output | 2 | Thread of the selected entry |
| sel_tag | output | 4 | Tag of the selected entry |
| rem_valid | input | 1 | Remove an entry by tag |
| rem_bank | input | BANK_W | Bank of the entry to remove |
| rem_tag | input | 4 | Tag of the entry to remove |
| pop_valid | input | 1 | Remove the head of `pop_bank` |
| pop_bank | input | BANK_W | Bank whose head is shown and popped |
| pop_row | output | 8 | Row of the head entry |
| pop_thread | output | 2 | Thread of the head entry |
| pop_tag | output | 4 | Tag of the head entry |
| empty | output | 1 | All bank queues are empty |

## Verification
The selection, head and ready outputs are combinational views of registered queue state. They are due within the same cycle as a change of `qry_bank`, `pop_bank`, `enq_bank` or `mode_ext`/`ext_open_row`. Enqueue, removal and pop change that state at the one clock edge that follows the request, so their effect is due one cycle later. The bench drives every input on the falling edge and removes it on the next falling edge, so exactly one rising edge lies between the two. It then reads results a nanosecond after the falling edge, where both the same-cycle views and the one-edge updates have settled.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int ROW_W = 8;
  localparam int THR_W = 2;
  localparam int TAG_W = 4;

  typedef struct packed {
    logic [ROW_W-1:0] row;
    logic [THR_W-1:0] thread;
    logic [TAG_W-1:0] tag;
  } entry_t;
endpackage

// File: rtl/sched_oldest_pick.sv
module sched_oldest_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest index is the oldest slot
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/sched_open_rows.sv
module sched_open_rows
  import sched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       upd_en,
  input  logic [BANK_W-1:0]          upd_bank,
  input  logic [ROW_W-1:0]           upd_row,
  output logic [NUM_BANKS-1:0]       row_vld,
  output logic [NUM_BANKS*ROW_W-1:0] rows
);
  always_ff @(posedge clk) begin
    if (rst) begin
      row_vld <= '0;
      rows    <= '0;
    end else if (upd_en) begin
      row_vld[upd_bank]               <= 1'b1;
      rows[upd_bank*ROW_W +: ROW_W]   <= upd_row;
    end
  end
endmodule

// File: rtl/sched_bank_queue.sv
module sched_bank_queue
  import sched_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  entry_t           push_ent,
  input  logic             del_tag_en,
  input  logic [TAG_W-1:0] del_tag,
  input  logic             del_head,
  input  logic             open_vld,
  input  logic [ROW_W-1:0] open_row,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output entry_t           head,
  output entry_t           pick,
  output logic             pick_hit,
  output logic             tag_found,
  output logic [ROW_W-1:0] tag_row
);
  entry_t mem [DEPTH];

  logic [DEPTH-1:0] occ;
  logic [DEPTH-1:0] hit_vec;
  logic [DEPTH-1:0] tag_vec;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] tag_idx;
  logic [IDX_W-1:0] del_idx;
  logic             del_en;
  logic [CNT_W-1:0] after_del;
  logic [IDX_W-1:0] wr_idx;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      assign occ[g]     = CNT_W'(g) < count;
      assign hit_vec[g] = occ[g] && open_vld && (mem[g].row == open_row);
      assign tag_vec[g] = occ[g] && (mem[g].tag == del_tag);
    end
  endgenerate

  sched_oldest_pick #(.N(DEPTH)) hit_pick_i (
    .req (hit_vec),
    .any (pick_hit),
    .idx (hit_idx)
  );

  sched_oldest_pick #(.N(DEPTH)) tag_pick_i (
    .req (tag_vec),
    .any (tag_found),
    .idx (tag_idx)
  );

  assign full    = (count == CNT_W'(DEPTH));
  assign head    = mem[0];
  assign pick    = pick_hit ? mem[hit_idx] : mem[0];
  assign tag_row = mem[tag_idx].row;

  always_comb begin
    if (del_head && count != '0) begin
      del_en  = 1'b1;
      del_idx = '0;
    end else if (del_tag_en && tag_found) begin
      del_en  = 1'b1;
      del_idx = tag_idx;
    end else begin
      del_en  = 1'b0;
      del_idx = '0;
    end
  end

  assign after_del = count - CNT_W'(del_en);
  assign wr_idx    = after_del[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= after_del + CNT_W'(push);
  end

  // storage has no reset; occupancy is carried by count
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (del_en && IDX_W'(i) >= del_idx) mem[i] <= mem[i+1];
    end
    if (push) mem[wr_idx] <= push_ent;
  end
endmodule

// File: rtl/rowhit_bank_sched.sv
module rowhit_bank_sched
  import sched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 8,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mode_ext,
  input  logic [NUM_BANKS*ROW_W-1:0] ext_open_row,
  input  logic                       enq_valid,
  input  logic [BANK_W-1:0]          enq_bank,
  input  logic [ROW_W-1:0]           enq_row,
  input  logic [THR_W-1:0]           enq_thread,
  input  logic [TAG_W-1:0]           enq_tag,
  output logic                       enq_ready,
  input  logic                       qry_valid,
  input  logic [BANK_W-1:0]          qry_bank,
  output logic                       sel_valid,
  output logic                       sel_hit,
  output logic [ROW_W-1:0]           sel_row,
  output logic [THR_W-1:0]           sel_thread,
  output logic [TAG_W-1:0]           sel_tag,
  input  logic                       rem_valid,
  input  logic [BANK_W-1:0]          rem_bank,
  input  logic [TAG_W-1:0]           rem_tag,
  input  logic                       pop_valid,
  input  logic [BANK_W-1:0]          pop_bank,
  output logic [ROW_W-1:0]           pop_row,
  output logic [THR_W-1:0]           pop_thread,
  output logic [TAG_W-1:0]           pop_tag,
  output logic                       empty
);
  entry_t                     new_ent;
  entry_t                     head_e  [NUM_BANKS];
  entry_t                     pick_e  [NUM_BANKS];
  logic [ROW_W-1:0]           tag_row [NUM_BANKS];
  logic [ROW_W-1:0]           eff_row [NUM_BANKS];
  logic [NUM_BANKS-1:0]       eff_vld;
  logic [NUM_BANKS-1:0]       full_v;
  logic [NUM_BANKS-1:0]       hit_v;
  logic [NUM_BANKS-1:0]       tag_found_v;
  logic [NUM_BANKS-1:0]       nonempty_v;
  logic [NUM_BANKS*CNT_W-1:0] cnt_flat;
  logic [NUM_BANKS-1:0]       int_vld;
  logic [NUM_BANKS*ROW_W-1:0] int_rows;
  logic                       upd_en;
  entry_t                     sel_e;
  entry_t                     head_sel;

  assign new_ent = '{row: enq_row, thread: enq_thread, tag: enq_tag};

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [CNT_W-1:0] cnt_b;

      assign eff_vld[b] = mode_ext | int_vld[b];
      assign eff_row[b] = mode_ext ? ext_open_row[b*ROW_W +: ROW_W]
                                   : int_rows[b*ROW_W +: ROW_W];

      sched_bank_queue #(.DEPTH(DEPTH)) queue_i (
        .clk        (clk),
        .rst        (rst),
        .push       (enq_valid && enq_bank == BANK_W'(b) && !full_v[b]),
        .push_ent   (new_ent),
        .del_tag_en (rem_valid && rem_bank == BANK_W'(b)),
        .del_tag    (rem_tag),
        .del_head   (pop_valid && pop_bank == BANK_W'(b)),
        .open_vld   (eff_vld[b]),
        .open_row   (eff_row[b]),
        .count      (cnt_b),
        .full       (full_v[b]),
        .head       (head_e[b]),
        .pick       (pick_e[b]),
        .pick_hit   (hit_v[b]),
        .tag_found  (tag_found_v[b]),
        .tag_row    (tag_row[b])
      );

      assign cnt_flat[b*CNT_W +: CNT_W] = cnt_b;
      assign nonempty_v[b]              = (cnt_b != '0);
    end
  endgenerate

  assign upd_en = !mode_ext && rem_valid && tag_found_v[rem_bank];

  sched_open_rows #(.NUM_BANKS(NUM_BANKS)) rows_i (
    .clk      (clk),
    .rst      (rst),
    .upd_en   (upd_en),
    .upd_bank (rem_bank),
    .upd_row  (tag_row[rem_bank]),
    .row_vld  (int_vld),
    .rows     (int_rows)
  );

  assign enq_ready  = !full_v[enq_bank];

  assign sel_e      = pick_e[qry_bank];
  assign sel_valid  = nonempty_v[qry_bank];
  assign sel_hit    = nonempty_v[qry_bank] && hit_v[qry_bank];
  assign sel_row    = sel_e.row;
  assign sel_thread = sel_e.thread;
  assign sel_tag    = sel_e.tag;

  assign head_sel   = head_e[pop_bank];
  assign pop_row    = head_sel.row;
  assign pop_thread = head_sel.thread;
  assign pop_tag    = head_sel.tag;

  assign empty      = ~|nonempty_v;
endmodule

// File: rtl/rowhit_bank_sched_chk.sv
module rowhit_bank_sched_chk
  import sched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 8,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       mode_ext,
  input logic [NUM_BANKS*ROW_W-1:0] ext_open_row,
  input logic                       qry_valid,
  input logic [BANK_W-1:0]          qry_bank,
  input logic                       sel_valid,
  input logic                       sel_hit,
  input logic [ROW_W-1:0]           sel_row,
  input logic                       rem_valid,
  input logic [BANK_W-1:0]          rem_bank,
  input logic                       pop_valid,
  input logic [BANK_W-1:0]          pop_bank,
  input logic                       empty,
  input logic [NUM_BANKS-1:0]       tag_found_v,
  input logic [NUM_BANKS*CNT_W-1:0] cnt_flat
);
  assert_query_nonempty_R9: assert property (@(posedge clk) disable iff (rst)
    qry_valid |-> sel_valid);

  assert_ext_hit_row_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_ext && sel_valid && sel_hit) |->
      (sel_row == ext_open_row[qry_bank*ROW_W +: ROW_W]));

  assert_remove_present_R6: assert property (@(posedge clk) disable iff (rst)
    rem_valid |-> tag_found_v[rem_bank]);

  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> (cnt_flat[pop_bank*CNT_W +: CNT_W] != '0));

  assert_no_pop_rem_clash_R7: assert property (@(posedge clk) disable iff (rst)
    !(pop_valid && rem_valid && pop_bank == rem_bank));

  assert_empty_after_removal_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(empty) |-> $past(rem_valid || pop_valid));

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bound
      assert_fill_bound_R1: assert property (@(posedge clk) disable iff (rst)
        cnt_flat[b*CNT_W +: CNT_W] <= CNT_W'(DEPTH));
    end
  endgenerate
endmodule

bind rowhit_bank_sched rowhit_bank_sched_chk #(
  .NUM_BANKS (NUM_BANKS),
  .DEPTH     (DEPTH)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .mode_ext     (mode_ext),
  .ext_open_row (ext_open_row),
  .qry_valid    (qry_valid),
  .qry_bank     (qry_bank),
  .sel_valid    (sel_valid),
  .sel_hit      (sel_hit),
  .sel_row      (sel_row),
  .rem_valid    (rem_valid),
  .rem_bank     (rem_bank),
  .pop_valid    (pop_valid),
  .pop_bank     (pop_bank),
  .empty        (empty),
  .tag_found_v  (tag_found_v),
  .cnt_flat     (cnt_flat)
);

// File: tb/rowhit_bank_sched_tb_top.sv
module rowhit_bank_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        mode_ext;
  logic [31:0] ext_open_row;
  logic        enq_valid;
  logic [1:0]  enq_bank;
  logic [7:0]  enq_row;
  logic [1:0]  enq_thread;
  logic [3:0]  enq_tag;
  logic        enq_ready;
  logic        qry_valid;
  logic [1:0]  qry_bank;
  logic        sel_valid;
  logic        sel_hit;
  logic [7:0]  sel_row;
  logic [1:0]  sel_thread;
  logic [3:0]  sel_tag;
  logic        rem_valid;
  logic [1:0]  rem_bank;
  logic [3:0]  rem_tag;
  logic        pop_valid;
  logic [1:0]  pop_bank;
  logic [7:0]  pop_row;
  logic [1:0]  pop_thread;
  logic [3:0]  pop_tag;
  logic        empty;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  rowhit_bank_sched dut_i (
    .clk(clk), .rst(rst), .mode_ext(mode_ext), .ext_open_row(ext_open_row),
    .enq_valid(enq_valid), .enq_bank(enq_bank), .enq_row(enq_row),
    .enq_thread(enq_thread), .enq_tag(enq_tag), .enq_ready(enq_ready),
    .qry_valid(qry_valid), .qry_bank(qry_bank), .sel_valid(sel_valid),
    .sel_hit(sel_hit), .sel_row(sel_row), .sel_thread(sel_thread),
    .sel_tag(sel_tag), .rem_valid(rem_valid), .rem_bank(rem_bank),
    .rem_tag(rem_tag), .pop_valid(pop_valid), .pop_bank(pop_bank),
    .pop_row(pop_row), .pop_thread(pop_thread), .pop_tag(pop_tag),
    .empty(empty)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic enq(input int b, input int row, input int thr, input int tag);
    @(negedge clk);
    enq_valid = 1; enq_bank = 2'(b); enq_row = 8'(row);
    enq_thread = 2'(thr); enq_tag = 4'(tag);
    @(negedge clk);
    enq_valid = 0;
    #1;
  endtask

  task automatic remove(input int b, input int tag);
    @(negedge clk);
    rem_valid = 1; rem_bank = 2'(b); rem_tag = 4'(tag);
    @(negedge clk);
    rem_valid = 0;
    #1;
  endtask

  task automatic pop_expect(input string req, input int b, input int tag);
    @(negedge clk);
    pop_bank = 2'(b);
    #1;
    chk(req, "pop_tag", int'(pop_tag), tag);
    pop_valid = 1;
    @(negedge clk);
    pop_valid = 0;
    #1;
  endtask

  task automatic query_expect(input string req, input int b, input int tag,
                              input int hit, input int row);
    qry_bank = 2'(b);
    #1;
    chk(req, "sel_valid", int'(sel_valid), 1);
    chk(req, "sel_tag", int'(sel_tag), tag);
    chk(req, "sel_hit", int'(sel_hit), hit);
    chk(req, "sel_row", int'(sel_row), row);
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    qry_bank = 0; enq_bank = 0;
    #1;
    chk("R8", "empty after reset", int'(empty), 1);
    chk("R9", "sel_valid on empty bank", int'(sel_valid), 0);
    chk("R1", "enq_ready after reset", int'(enq_ready), 1);
  endtask

  task automatic t_age_and_pop;
    mode_ext = 0;
    enq(1, 5, 0, 1);
    enq(1, 6, 1, 2);
    enq(1, 5, 2, 3);
    chk("R8", "empty with entries", int'(empty), 0);
    query_expect("R3_R5", 1, 1, 0, 5);
    chk("R3", "sel_thread", int'(sel_thread), 0);
    pop_expect("R7", 1, 1);
    // pop must not open row 5, so tag 3 is no hit
    query_expect("R7_R1", 1, 2, 0, 6);
  endtask

  task automatic t_internal_hits;
    enq(1, 6, 3, 4);
    remove(1, 3);               // private row of bank 1 becomes 5
    query_expect("R5_R3", 1, 2, 0, 6);
    remove(1, 2);               // private row becomes 6
    query_expect("R5_R2", 1, 4, 1, 6);
    chk("R2", "sel_thread", int'(sel_thread), 3);
    enq(1, 9, 0, 5);
    enq(1, 6, 1, 6);
    remove(1, 4);               // queue: 5(row9), 6(row6)
    query_expect("R2", 1, 6, 1, 6);
    enq(1, 6, 2, 7);            // queue: 5, 6, 7
    query_expect("R2", 1, 6, 1, 6);
    remove(1, 6);               // middle removal
    query_expect("R6", 1, 7, 1, 6);
    pop_expect("R6", 1, 5);
    pop_expect("R6", 1, 7);
    qry_bank = 1;
    #1;
    chk("R9", "bank1 drained", int'(sel_valid), 0);
  endtask

  task automatic t_external;
    mode_ext = 1;
    ext_open_row = 32'h0014_0000;   // bank 2 -> 20
    enq(2, 10, 0, 8);
    enq(2, 20, 1, 9);
    enq(2, 20, 2, 10);
    query_expect("R4", 2, 9, 1, 20);
    ext_open_row[23:16] = 8'd30;
    query_expect("R4", 2, 8, 0, 10);
    ext_open_row[23:16] = 8'd20;
    remove(2, 9);
    mode_ext = 0;
    // removal under external mode left private row of bank 2 unset
    query_expect("R5", 2, 8, 0, 10);
  endtask

  task automatic t_full;
    for (int i = 0; i < 8; i++) enq(3, 40 + i, i % 4, i);
    enq_bank = 3;
    #1;
    chk("R1", "enq_ready full bank", int'(enq_ready), 0);
    enq(3, 99, 0, 15);          // dropped
    enq_bank = 0;
    #1;
    chk("R1", "enq_ready other bank", int'(enq_ready), 1);
    remove(3, 3);
    for (int i = 0; i < 8; i++) begin
      if (i != 3) pop_expect("R1_R6", 3, i);
    end
    qry_bank = 3;
    #1;
    chk("R1", "overflow entry absent", int'(sel_valid), 0);
    chk("R8", "empty while bank2 busy", int'(empty), 0);
    pop_expect("R8", 2, 8);
    pop_expect("R8", 2, 10);
    chk("R8", "empty after drain", int'(empty), 1);
  endtask

  initial begin
    rst = 1; mode_ext = 0; ext_open_row = '0;
    enq_valid = 0; enq_bank = 0; enq_row = 0; enq_thread = 0; enq_tag = 0;
    qry_valid = 0; qry_bank = 0;
    rem_valid = 0; rem_bank = 0; rem_tag = 0;
    pop_valid = 0; pop_bank = 0;
    t_reset();
    t_age_and_pop();
    t_internal_hits();
    t_external();
    t_full();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule